// File: doc/BRIEF.md
# Filtered-Sample Integrator with Shifted Output Window

This block sits behind a decimation filter. It sums a programmable number of signed filter samples into a 32-bit accumulator. The sum is handed to the output in one of two ways. In count mode, a transfer happens once a set number of samples has arrived. In hold mode, a transfer happens on an external sample-and-hold strobe. The integrator can also be bypassed, so that each raw filter sample goes straight to the output.

The output word is either the full 32-bit two's complement result or a 16-bit two's complement window taken from the result. The window can be moved up the result by a programmable number of bits. When the window cannot hold the value, it clamps to the signed 16-bit limits. A 16-bit result is sign-extended onto the 32-bit output bus. Each update comes with a one-cycle data-ready pulse.

Settings live in a 16-bit configuration register that reset clears to zero. Writing the register restarts any accumulation that is in progress.

Top module: `sfi_integrator`

## Requirements
- R1: The configuration register loads `cfg_data` on a cycle with `cfg_wr` high, and the new value takes effect from the following cycle. The field layout is: bits 15:9 ratio code, bit 8 demodulation flag (stored only), bit 7 hold mode, bit 6 integrator enable, bit 5 32-bit format, bits 4:0 shift. Reset clears the register, `dout` and `dready` to zero.
- R2: With integrator enable at 0, every valid sample is sign-extended to 32 bits and passed through the selected format. The result appears on `dout`, with `dready` high, one clock after the sample.
- R3: In count mode (hold mode 0, integrator enable 1), a ratio code N sums N+1 samples. The output updates one clock after the sample that completes the group.
- R4: In hold mode, the output updates one clock after each `hold_strobe` with the sum of the samples taken since the previous transfer. Samples alone never update the output in hold mode, and `hold_strobe` has no effect in count mode.
- R5: In hold mode, a sample that arrives in the same cycle as `hold_strobe` is included in the sum that is transferred.
- R6: The accumulator clears at every transfer, so each sum covers only the samples after the previous transfer. A strobe with no samples since the previous transfer yields zero.
- R7: With the 32-bit format bit at 1, `dout` carries the full 32-bit two's complement result.
- R8: With the 32-bit format bit at 0, the window value is the result arithmetically shifted right by the shift field (0 to 31). Its low 16 bits are sign-extended onto `dout`.
- R9: In 16-bit format, a shifted value above 32767 gives 0x00007FFF and one below -32768 gives 0xFFFF8000.
- R10: `dready` is high for one cycle per update and only after an update cause. `dout` holds its value between updates.
- R11: A configuration write discards any partial sum and sample count. The demodulation flag has no effect on `dout` or `dready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_data | input | 16 | Configuration word to load |
| samp_valid | input | 1 | Filter sample valid |
| samp_data | input | SAMP_W (24) | Signed filter sample |
| hold_strobe | input | 1 | External sample-and-hold strobe |
| dout | output | 32 | Output data word |
| dready | output | 1 | One-cycle data-ready pulse |

## Verification
The assertions assume that the accumulated sum never leaves the signed 32-bit range. They also assume that a configuration write is never issued in the same cycle as a sample or strobe that the caller expects to be used. The stimulus respects both limits. Sample magnitudes and ratio codes are chosen so that even the longest group (128 samples near the 24-bit limit) stays below 2^31. Every configuration write is issued with `samp_valid` and `hold_strobe` low, and the next sample comes on the following cycle.

// File: rtl/sfi_pkg.sv
package sfi_pkg;

    localparam int ACC_W   = 32;
    localparam int OUT_W   = 32;
    localparam int WIN_W   = 16;
    localparam int SHIFT_W = 5;
    localparam int RATIO_W = 7;
    localparam int CFG_W   = 16;

    // Configuration word, MSB first: ratio code, demod flag, hold mode,
    // integrator enable, 32-bit format, window shift.
    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               demod_en;
        logic               hold_mode;
        logic               integ_en;
        logic               fmt32;
        logic [SHIFT_W-1:0] shift;
    } sfi_cfg_t;

    // Source of an output transfer in the current cycle.
    typedef enum logic [1:0] {
        XF_NONE = 2'd0,
        XF_RAW  = 2'd1,
        XF_CNT  = 2'd2,
        XF_HOLD = 2'd3
    } xfer_src_e;

    typedef struct packed {
        xfer_src_e                src;
        logic signed [ACC_W-1:0]  value;
    } xfer_t;

    // Arithmetic shift right, then clamp into a signed 16-bit window,
    // sign-extended to the output width.
    function automatic logic [OUT_W-1:0] window_sat(
        input logic signed [ACC_W-1:0] v,
        input logic [SHIFT_W-1:0]      sh
    );
        logic signed [ACC_W-1:0] s;
        logic [ACC_W-WIN_W:0]    upper;
        s     = v >>> sh;
        upper = s[ACC_W-1:WIN_W-1];
        if ((&upper) || !(|upper))
            return {{(OUT_W-WIN_W){s[WIN_W-1]}}, s[WIN_W-1:0]};
        else if (s[ACC_W-1])
            return {{(OUT_W-WIN_W){1'b1}}, 1'b1, {(WIN_W-1){1'b0}}};
        else
            return {{(OUT_W-WIN_W+1){1'b0}}, {(WIN_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/sfi_cfg_reg.sv
module sfi_cfg_reg
    import sfi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output sfi_cfg_t         cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr)
            cfg_q <= sfi_cfg_t'(wdata);
    end

    // Configuration only changes on a write.
    assert_cfg_stable_R1: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(cfg_q));

    assert_cfg_load_R1: assert property (@(posedge clk) disable iff (rst)
        wr |=> (cfg_q == sfi_cfg_t'($past(wdata))));

endmodule

// File: rtl/sfi_accum.sv
module sfi_accum
    import sfi_pkg::*;
#(
    parameter int SAMP_W = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     restart,
    input  logic                     integ_en,
    input  logic                     hold_mode,
    input  logic [RATIO_W-1:0]       ratio,
    input  logic                     samp_valid,
    input  logic signed [SAMP_W-1:0] samp_data,
    input  logic                     hold_strobe,
    output xfer_t                    xfer
);

    logic signed [ACC_W-1:0] acc_q;
    logic [RATIO_W-1:0]      cnt_q;
    logic signed [ACC_W-1:0] samp_ext;
    logic signed [ACC_W-1:0] sum;

    generate
        if (ACC_W > SAMP_W) begin : g_ext
            assign samp_ext = {{(ACC_W-SAMP_W){samp_data[SAMP_W-1]}}, samp_data};
        end else begin : g_noext
            assign samp_ext = samp_data[ACC_W-1:0];
        end
    endgenerate

    assign sum = samp_valid ? (acc_q + samp_ext) : acc_q;

    always_comb begin
        xfer.src   = XF_NONE;
        xfer.value = sum;
        if (restart) begin
            xfer.src = XF_NONE;
        end else if (!integ_en) begin
            xfer.value = samp_ext;
            if (samp_valid)
                xfer.src = XF_RAW;
        end else if (hold_mode) begin
            if (hold_strobe)
                xfer.src = XF_HOLD;
        end else begin
            if (samp_valid && (cnt_q == ratio))
                xfer.src = XF_CNT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !integ_en) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (xfer.src != XF_NONE) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (samp_valid) begin
            acc_q <= sum;
            if (!hold_mode)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // Count mode never holds more than ratio+1 samples.
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (integ_en && !hold_mode && !restart) |=> (cnt_q <= ratio));

    // After a transfer the next sum starts from zero.
    assert_clear_after_xfer_R6: assert property (@(posedge clk) disable iff (rst)
        (xfer.src != XF_NONE) |=> (acc_q == '0));

    // A count-mode transfer only happens on a sample.
    assert_cnt_needs_sample_R3: assert property (@(posedge clk) disable iff (rst)
        (xfer.src == XF_CNT) |-> samp_valid);

endmodule

// File: rtl/sfi_out_stage.sv
module sfi_out_stage
    import sfi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  xfer_t              xfer,
    input  logic               fmt32,
    input  logic [SHIFT_W-1:0] shift,
    output logic [OUT_W-1:0]   dout,
    output logic               dready
);

    logic [OUT_W-1:0] formatted;

    always_comb begin
        if (fmt32)
            formatted = OUT_W'(xfer.value);
        else
            formatted = window_sat(xfer.value, shift);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout   <= '0;
            dready <= 1'b0;
        end else begin
            dready <= (xfer.src != XF_NONE);
            if (xfer.src != XF_NONE)
                dout <= formatted;
        end
    end

    // A 16-bit result is always a sign extension on the wide bus.
    assert_win_sext_R8: assert property (@(posedge clk) disable iff (rst)
        (dready && !$past(fmt32)) |-> (dout[OUT_W-1:WIN_W] == {(OUT_W-WIN_W){dout[WIN_W-1]}}));

    // The output word holds between updates.
    assert_dout_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !dready |-> $stable(dout));

endmodule

// File: rtl/sfi_integrator.sv
module sfi_integrator
    import sfi_pkg::*;
#(
    parameter int SAMP_W = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_wr,
    input  logic [15:0]              cfg_data,
    input  logic                     samp_valid,
    input  logic signed [SAMP_W-1:0] samp_data,
    input  logic                     hold_strobe,
    output logic [31:0]              dout,
    output logic                     dready
);

    sfi_cfg_t cfg_q;
    xfer_t    xfer;

    sfi_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (cfg_data),
        .cfg_q (cfg_q)
    );

    sfi_accum #(.SAMP_W(SAMP_W)) u_accum (
        .clk         (clk),
        .rst         (rst),
        .restart     (cfg_wr),
        .integ_en    (cfg_q.integ_en),
        .hold_mode   (cfg_q.hold_mode),
        .ratio       (cfg_q.ratio),
        .samp_valid  (samp_valid),
        .samp_data   (samp_data),
        .hold_strobe (hold_strobe),
        .xfer        (xfer)
    );

    sfi_out_stage u_out (
        .clk    (clk),
        .rst    (rst),
        .xfer   (xfer),
        .fmt32  (cfg_q.fmt32),
        .shift  (cfg_q.shift),
        .dout   (dout),
        .dready (dready)
    );

    // A data-ready pulse always follows a sample or a strobe.
    assert_ready_cause_R10: assert property (@(posedge clk) disable iff (rst)
        dready |-> $past(samp_valid || hold_strobe));

    // Bypass with 32-bit format hands over the sign-extended sample.
    assert_raw_path_R2: assert property (@(posedge clk) disable iff (rst)
        (dready && $past(!cfg_q.integ_en && cfg_q.fmt32))
            |-> ($signed(dout) == $past(32'(samp_data))));

    // No update may follow a configuration write cycle.
    assert_wr_no_ready_R11: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> !dready);

endmodule

// File: tb/sfi_integrator_tb.sv
module sfi_integrator_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst;
    logic               cfg_wr;
    logic [15:0]        cfg_data;
    logic               samp_valid;
    logic signed [23:0] samp_data;
    logic               hold_strobe;
    logic [31:0]        dout;
    logic               dready;

    sfi_integrator u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .samp_valid(samp_valid), .samp_data(samp_data),
        .hold_strobe(hold_strobe), .dout(dout), .dready(dready)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    string       cur_tag = "R1";

    // reference model state
    logic signed [31:0] m_acc;
    int                 m_cnt;
    int                 m_ratio;
    logic [4:0]         m_shift;
    logic               m_fmt32, m_integ, m_hold;
    logic [31:0]        last_dout;
    logic               mon_on = 1'b0;
    logic               done = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_fmt(input logic signed [31:0] r);
        longint s;
        if (m_fmt32) return r;
        s = longint'(r) >>> m_shift;
        if (s > 32767)  return 32'h0000_7FFF;
        if (s < -32768) return 32'hFFFF_8000;
        return 32'(s);
    endfunction

    task automatic push(input logic signed [31:0] r);
        exp_q.push_back(expect_fmt(r));
        tag_q.push_back(cur_tag);
    endtask

    task automatic write_cfg(input int ratio, input logic demod, input logic hold,
                             input logic integ, input logic fmt32, input int sh);
        @(negedge clk);
        cfg_wr      = 1'b1;
        cfg_data    = {7'(ratio), demod, hold, integ, fmt32, 5'(sh)};
        samp_valid  = 1'b0;
        hold_strobe = 1'b0;
        m_ratio = ratio; m_shift = 5'(sh); m_fmt32 = fmt32;
        m_integ = integ; m_hold = hold;
        m_acc = '0; m_cnt = 0;
    endtask

    task automatic step(input logic v, input int d, input logic hs);
        logic signed [23:0] d24;
        logic signed [31:0] ext;
        logic signed [31:0] sum;
        @(negedge clk);
        d24 = 24'(d);
        ext = 32'(d24);
        cfg_wr      = 1'b0;
        samp_valid  = v;
        samp_data   = d24;
        hold_strobe = hs;
        sum = v ? m_acc + ext : m_acc;
        if (!m_integ) begin
            if (v) push(ext);
        end else if (m_hold) begin
            if (hs) begin push(sum); m_acc = '0; end
            else m_acc = sum;
        end else if (v) begin
            if (m_cnt == m_ratio) begin push(sum); m_acc = '0; m_cnt = 0; end
            else begin m_acc = sum; m_cnt++; end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (dready) begin
                    if (exp_q.size() == 0) begin
                        checks++; fails++;
                        $display("FAIL R10: actual=unexpected dready dout=%h expected=no update", dout);
                    end else begin
                        check(tag_q.pop_front(), dout, exp_q.pop_front());
                    end
                    last_dout = dout;
                end else begin
                    check("R10 hold", dout, last_dout);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_data = '0;
        samp_valid = 1'b0; samp_data = '0; hold_strobe = 1'b0;
        m_acc = '0; m_cnt = 0; m_ratio = 0; m_shift = '0;
        m_fmt32 = 1'b0; m_integ = 1'b0; m_hold = 1'b0;
        last_dout = '0;
        repeat (3) @(negedge clk);
        check("R1 reset dout", dout, 32'h0);
        check("R1 reset dready", {31'b0, dready}, 32'h0);
        rst = 1'b0;
        mon_on = 1'b1;

        // R1/R2/R9: reset config is raw bypass, 16-bit, shift 0
        cur_tag = "R2 R9 raw16";
        step(1, 5, 0); step(1, -3, 0); idle(1);
        step(1, 40000, 0); step(1, -40000, 0); step(0, 0, 1);
        idle(2);

        // R2/R7: raw bypass, 32-bit
        write_cfg(0, 0, 0, 0, 1, 0);
        cur_tag = "R2 R7 raw32";
        step(1, 123456, 0); step(1, -7, 0); step(1, -8388608, 0);
        idle(2);

        // R3/R4/R6: count mode ratio 4, strobes ignored
        write_cfg(3, 0, 0, 1, 1, 0);
        cur_tag = "R3 R4 R6 count4";
        step(1, 10, 0); step(0, 0, 1); step(1, 20, 1); step(1, -5, 0);
        step(1, 100, 0);
        step(1, 1, 0); idle(2); step(1, 2, 0); step(1, 3, 0); step(1, 4, 0);
        idle(2);

        // R3: ratio code 0 transfers every sample
        write_cfg(0, 0, 0, 1, 1, 0);
        cur_tag = "R3 ratio1";
        step(1, 77, 0); step(1, -77, 0); step(1, 9, 0);
        idle(2);

        // R3: ratio code 127, near-full-scale samples
        write_cfg(127, 0, 0, 1, 1, 0);
        cur_tag = "R3 ratio128";
        for (int i = 0; i < 128; i++) step(1, 8000000, 0);
        idle(2);

        // R8/R9: 16-bit window with shifts
        write_cfg(1, 0, 0, 1, 0, 8);
        cur_tag = "R8 R9 shift8";
        step(1, 1000000, 0); step(1, 1000000, 0);
        step(1, 8000000, 0); step(1, 8000000, 0);
        step(1, -8000000, 0); step(1, -8000000, 0);
        step(1, -1000, 0); step(1, 1, 0);
        idle(2);
        write_cfg(0, 0, 0, 1, 0, 31);
        cur_tag = "R8 shift31";
        step(1, 5, 0); step(1, -5, 0);
        idle(2);
        write_cfg(0, 0, 0, 1, 0, 0);
        cur_tag = "R8 R9 shift0";
        step(1, 32767, 0); step(1, 32768, 0); step(1, -32768, 0); step(1, -32769, 0);
        idle(2);

        // R4/R5/R6: hold mode
        write_cfg(0, 0, 1, 1, 1, 0);
        cur_tag = "R4 R5 R6 hold";
        step(1, 11, 0); step(1, 22, 0); step(1, 33, 0); idle(2);
        step(0, 0, 1);
        step(1, 4, 0); step(1, 6, 1);
        step(0, 0, 1);
        step(1, -50, 1); step(1, 8, 0);
        idle(2); step(0, 0, 1);
        idle(2);

        // R11: config write discards partial sums; demod flag has no effect
        write_cfg(3, 1, 0, 1, 1, 0);
        cur_tag = "R11 restart demod";
        step(1, 500, 0); step(1, 500, 0);
        write_cfg(3, 1, 0, 1, 1, 0);
        step(1, 1, 0); step(1, 2, 0); step(1, 3, 0); step(1, 4, 0);
        write_cfg(0, 1, 1, 1, 1, 0);
        step(1, 40, 0); step(0, 0, 1);
        idle(3);

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R10: actual=%0d missing updates expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule